// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns one active-low external interrupt pin into a single request line for the interrupt sequencer of a small 8-bit CPU. The pin is brought into the clock domain through a short synchronizer chain, and falling edges are found on the synchronized level. A sense-mode input chooses how the pin is read. With the mode at 1, only falling edges count. With the mode at 0, a falling edge or a held low level both raise a request. The mode register that drives this input resets to 0 in the surrounding system.

Edges are held in a one-deep pending latch. In edge mode the latch captures a falling edge whatever the state of the CPU mask, so an edge seen while the mask is set is served as soon as the mask clears. The latch is emptied by reset and by the CPU's fetch of this interrupt's vector, which the sequencer signals on a one-cycle acknowledge. An edge that lands in the same cycle as that acknowledge is kept. In level mode a low pulse that ends while the mask is set leaves no trace. A separate inhibit input suppresses every request and stops edges from being captured.

Top module: `extint_detector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the request output is low and the pending latch is empty.
- R2: A change on the raw pin reaches the request output on the third rising clock edge after the change and not earlier. Mask, inhibit and acknowledge changes reach it on the first rising edge.
- R3: In level mode (mode input = 0), with mask and inhibit low, the request is high whenever the synchronized pin is low. It therefore comes back after an acknowledge for as long as the pin stays low, and it drops once the pin returns high and nothing is pending.
- R4: In level mode, a low pulse that begins and ends while the mask is set produces no request once the mask clears.
- R5: In edge mode (mode input = 1), after an acknowledge with the pin still low, the request stays low. Only a new falling edge raises it again.
- R6: In edge mode, a falling edge seen while the mask is set is held, and the request rises on the first edge after the mask clears.
- R7: Only one falling edge is held. Two edges while masked give one request, and after its acknowledge no second request follows.
- R8: An acknowledge with no coincident falling edge empties the pending latch. A reset also empties it.
- R9: While inhibit is high the request is low, and falling edges seen during inhibit are not captured.
- R10: A falling edge detected in the same cycle as an acknowledge is captured, so the request stays high through the acknowledge.
- R11: While the CPU mask is high the request is low.
- R12: In level mode with the mask low, a low pulse too short to be served is captured as an edge and holds the request high until acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPinN | input | 1 | Raw active-low interrupt pin, asynchronous to clk |
| edgeOnly | input | 1 | Sense mode: 1 = falling edge only, 0 = edge plus low level |
| inhibit | input | 1 | 1 blocks all requests and edge capture |
| cpuMask | input | 1 | CPU interrupt mask; 1 holds the request low |
| vecAck | input | 1 | One-cycle pulse while the CPU fetches this interrupt's vector |
| irqReq | output | 1 | Registered request to the interrupt sequencer |

## Verification
The request is a register. A mask, inhibit or acknowledge change is due on the first rising edge after it is applied. A raw pin change is due on the third edge, because it passes through two synchronizer stages and then the request flop. The driver applies every stimulus on a falling edge and files each expected value with the exact cycle it is due. The monitor compares only on falling edges at that cycle number, so each check lands one half period after the edge that should have produced the value. The coincident edge-and-acknowledge case is timed so that the acknowledge is present on exactly the edge where the synchronized falling edge is sampled.

// File: rtl/extint_pkg.sv
package extint_pkg;

  // Sense selection as presented on the mode input.
  typedef enum logic {
    SENSE_EDGE_LEVEL = 1'b0,
    SENSE_EDGE_ONLY  = 1'b1
  } senseMode_e;

  // Strobes from control to datapath, evaluated every cycle.
  typedef struct packed {
    logic setPend;    // capture a falling edge into the pending latch
    logic clrPend;    // vector fetched: empty the pending latch
    logic levelHold;  // level sensing asks for a request this cycle
    logic gateOpen;   // neither mask nor inhibit blocks the request
  } extintStrobes_t;

endpackage

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pinRaw,
  input  extintStrobes_t strb,
  output logic           fallEdge,
  output logic           pinLow,
  output logic           pendQ,
  output logic           irqReq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;
  logic                   pendNext;
  logic                   reqNext;

  // Synchronizer: idle level of the pin is high, so reset to ones.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
    end else begin
      for (int i = LAST; i > 0; i--) begin
        syncChain[i] <= syncChain[i-1];
      end
      syncChain[0] <= pinRaw;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b1;
    else       prevLevel <= syncChain[LAST];
  end

  assign pinLow   = ~syncChain[LAST];
  assign fallEdge = prevLevel & ~syncChain[LAST];

  // Set has priority so an edge coincident with the vector fetch survives.
  always_comb begin
    pendNext = pendQ;
    if (strb.clrPend) pendNext = 1'b0;
    if (strb.setPend) pendNext = 1'b1;
  end

  assign reqNext = strb.gateOpen & (pendNext | strb.levelHold);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= 1'b0;
      irqReq <= 1'b0;
    end else begin
      pendQ  <= pendNext;
      irqReq <= reqNext;
    end
  end

endmodule

// File: rtl/extint_control.sv
module extint_control
  import extint_pkg::*;
(
  input  logic           edgeOnly,
  input  logic           inhibit,
  input  logic           cpuMask,
  input  logic           vecAck,
  input  logic           fallEdge,
  input  logic           pinLow,
  output extintStrobes_t strb
);

  senseMode_e mode;

  assign mode = senseMode_e'(edgeOnly);

  always_comb begin
    strb = '0;
    strb.gateOpen = ~inhibit & ~cpuMask;
    strb.clrPend  = vecAck;
    unique case (mode)
      SENSE_EDGE_ONLY: begin
        // Edges are remembered even while masked.
        strb.setPend   = fallEdge & ~inhibit;
        strb.levelHold = 1'b0;
      end
      default: begin
        // Level sensing: a pulse hidden behind the mask is forgotten.
        strb.setPend   = fallEdge & ~inhibit & ~cpuMask;
        strb.levelHold = pinLow;
      end
    endcase
  end

endmodule

// File: rtl/extint_detector.sv
module extint_detector
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic irqPinN,
  input  logic edgeOnly,
  input  logic inhibit,
  input  logic cpuMask,
  input  logic vecAck,
  output logic irqReq
);

  extintStrobes_t strb;
  logic           fallEdge;
  logic           pinLow;
  logic           pendQ;

  extint_control u_ctrl (
    .edgeOnly (edgeOnly),
    .inhibit  (inhibit),
    .cpuMask  (cpuMask),
    .vecAck   (vecAck),
    .fallEdge (fallEdge),
    .pinLow   (pinLow),
    .strb     (strb)
  );

  extint_datapath #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinRaw   (irqPinN),
    .strb     (strb),
    .fallEdge (fallEdge),
    .pinLow   (pinLow),
    .pendQ    (pendQ),
    .irqReq   (irqReq)
  );

endmodule

// File: rtl/extint_checker.sv
module extint_checker (
  input logic clk,
  input logic rstN,
  input logic edgeOnly,
  input logic inhibit,
  input logic cpuMask,
  input logic vecAck,
  input logic fallEdge,
  input logic pendQ,
  input logic irqReq
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!irqReq && !pendQ));

  a_r9_inhibit_blocks: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |=> !irqReq);

  a_r11_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cpuMask |=> !irqReq);

  a_r10_edge_captured: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && !inhibit && (edgeOnly || !cpuMask)) |=> pendQ);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck && !fallEdge) |=> !pendQ);

  a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rstN)
    (edgeOnly && vecAck && !fallEdge) |=> !irqReq);

  a_r7_pend_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!fallEdge && !vecAck) |=> $stable(pendQ));

endmodule

bind extint_detector extint_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .edgeOnly (edgeOnly),
  .inhibit  (inhibit),
  .cpuMask  (cpuMask),
  .vecAck   (vecAck),
  .fallEdge (fallEdge),
  .pendQ    (pendQ),
  .irqReq   (irqReq)
);

// File: tb/tb_extint_detector.sv
`timescale 1ns/1ps
module tb_extint_detector;

  logic clk = 1'b0;
  logic rstN, irqPinN, edgeOnly, inhibit, cpuMask, vecAck;
  logic irqReq;

  always #4 clk = ~clk;

  extint_detector dut (
    .clk      (clk),
    .rstN     (rstN),
    .irqPinN  (irqPinN),
    .edgeOnly (edgeOnly),
    .inhibit  (inhibit),
    .cpuMask  (cpuMask),
    .vecAck   (vecAck),
    .irqReq   (irqReq)
  );

  typedef struct {
    int    due;
    logic  val;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int cycCount = 0;
  int errCnt   = 0;
  int chkCnt   = 0;
  bit doneFlag = 1'b0;

  always @(posedge clk) cycCount <= cycCount + 1;

  // Driver side: file an expected request value due d cycles from now.
  task automatic expectIn(input int d, input logic v, input string tag);
    expItem_t it;
    it.due = cycCount + d;
    it.val = v;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare every item due in this cycle, half a period after the edge.
  always @(negedge clk) begin
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].due == cycCount) begin
        chkCnt++;
        if (irqReq !== expQ[i].val) begin
          errCnt++;
          $display("FAIL %s cycle %0d: irqReq actual=%b expected=%b",
                   expQ[i].tag, cycCount, irqReq, expQ[i].val);
        end
        expQ.delete(i);
      end
    end
  end

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycCount > 3000 && !doneFlag) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; irqPinN = 1'b1; edgeOnly = 1'b0;
    inhibit = 1'b0; cpuMask = 1'b1; vecAck = 1'b0;
    step(1);
    expectIn(1, 1'b0, "R1 reset");
    step(3);
    rstN = 1'b0;
    step(1);
    // Release reset, open mask, level mode.
    rstN = 1'b1; cpuMask = 1'b0;
    expectIn(1, 1'b0, "R1 after reset");
    step(2);

    // R2 / R3: level mode, pin held low.
    irqPinN = 1'b0;
    expectIn(2, 1'b0, "R2 not before third edge");
    expectIn(3, 1'b1, "R2 third edge");
    step(3);
    cpuMask = 1'b1; vecAck = 1'b1;
    expectIn(1, 1'b0, "R11 mask during service");
    step(1);
    vecAck = 1'b0; cpuMask = 1'b0;
    expectIn(1, 1'b1, "R3 level re-asserts");
    step(2);
    irqPinN = 1'b1;
    expectIn(2, 1'b1, "R3 still low through sync");
    expectIn(3, 1'b0, "R3 release");
    step(4);

    // R4: pulse hidden behind the mask.
    cpuMask = 1'b1;
    expectIn(1, 1'b0, "R11 masked");
    irqPinN = 1'b0;
    step(4);
    irqPinN = 1'b1;
    step(4);
    cpuMask = 1'b0;
    expectIn(1, 1'b0, "R4 hidden pulse");
    expectIn(3, 1'b0, "R4 hidden pulse later");
    step(3);

    // R12: short pulse while unmasked is held until acknowledged.
    irqPinN = 1'b0;
    expectIn(3, 1'b1, "R12 short pulse raises");
    expectIn(6, 1'b1, "R12 held after pin high");
    step(1);
    irqPinN = 1'b1;
    step(5);
    vecAck = 1'b1;
    expectIn(1, 1'b0, "R8 ack clears");
    step(1);
    vecAck = 1'b0;
    expectIn(2, 1'b0, "R8 stays clear");
    step(2);

    // R6 / R7 / R5: edge mode.
    edgeOnly = 1'b1; cpuMask = 1'b1;
    irqPinN = 1'b0;
    expectIn(4, 1'b0, "R11 edge pending but masked");
    step(2);
    irqPinN = 1'b1;
    step(2);
    irqPinN = 1'b0;
    step(4);
    cpuMask = 1'b0;
    expectIn(1, 1'b1, "R6 pending fires on unmask");
    step(1);
    cpuMask = 1'b1; vecAck = 1'b1;
    expectIn(1, 1'b0, "R11 service");
    step(1);
    vecAck = 1'b0; cpuMask = 1'b0;
    expectIn(1, 1'b0, "R7 only one edge held");
    expectIn(3, 1'b0, "R5 low pin no repeat");
    step(3);
    irqPinN = 1'b1;
    step(3);
    irqPinN = 1'b0;
    expectIn(3, 1'b1, "R5 new edge raises");
    step(3);

    // R10: edge detected on the acknowledge cycle.
    irqPinN = 1'b1;
    step(4);
    irqPinN = 1'b0;
    step(2);
    vecAck = 1'b1;
    expectIn(1, 1'b1, "R10 coincident edge kept");
    step(1);
    vecAck = 1'b0;
    expectIn(1, 1'b1, "R10 still pending");
    step(1);
    vecAck = 1'b1;
    expectIn(1, 1'b0, "R8 plain ack clears");
    step(1);
    vecAck = 1'b0;
    step(1);

    // R9: inhibit in edge mode drops edges.
    irqPinN = 1'b1;
    step(4);
    inhibit = 1'b1;
    irqPinN = 1'b0;
    expectIn(1, 1'b0, "R9 inhibit");
    expectIn(3, 1'b0, "R9 edge blocked");
    expectIn(5, 1'b0, "R9 still blocked");
    step(5);
    inhibit = 1'b0;
    expectIn(1, 1'b0, "R9 edge not captured");
    expectIn(2, 1'b0, "R9 edge not captured later");
    step(2);
    // Level mode with pin low: inhibit gates it.
    edgeOnly = 1'b0; inhibit = 1'b1;
    expectIn(1, 1'b0, "R9 level inhibited");
    step(1);
    inhibit = 1'b0;
    expectIn(1, 1'b1, "R2 inhibit release one edge");
    step(1);
    inhibit = 1'b1;
    expectIn(1, 1'b0, "R9 inhibit reapplied");
    step(1);
    inhibit = 1'b0; cpuMask = 1'b1;
    expectIn(1, 1'b0, "R11 mask level");
    step(2);

    // R8: reset empties a held edge.
    edgeOnly = 1'b1;
    irqPinN = 1'b1;
    step(4);
    irqPinN = 1'b0;
    step(4);
    irqPinN = 1'b1;
    step(4);
    rstN = 1'b0;
    expectIn(1, 1'b0, "R1 reset again");
    step(2);
    rstN = 1'b1; cpuMask = 1'b0;
    expectIn(1, 1'b0, "R8 reset cleared pending");
    expectIn(3, 1'b0, "R8 reset cleared pending later");
    step(5);

    if (expQ.size() != 0) begin
      errCnt++;
      chkCnt++;
      $display("FAIL scoreboard: actual=%0d left expected=0", expQ.size());
    end
    finishRun();
  end

endmodule